// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Demultiplexer

This block holds eight single-bit storage cells. A 3-bit address picks one cell, and a single serial data input writes that cell. The same cells also act as a 3-to-8 demultiplexer with active-high outputs. Two active-low controls select one of four operating modes: a common clear and an enable. The modes are hold, addressed write, decode with every other output forced low, and clear.

Storage is a clocked register. A write or a clear takes effect on the rising clock edge while the controls select that mode. The parallel outputs are combinational. They are built from the current controls, address and data together with the stored contents. So in the write and decode modes the addressed output follows the data input at once. Callers are expected to change the address only while the block is in hold mode.

Top module: `addr_latch`

## Requirements
- R1: With `clrN`=1 and `enN`=1 (hold), `q` equals the stored contents. `dIn` and `addr` have no effect on `q` or on the stored contents, and across clock edges in this mode `q` stays unchanged.
- R2: With `clrN`=1 and `enN`=0 (write), output bit `q[addr]` equals `dIn` in the same cycle, with no clock edge needed.
- R3: In write mode every output bit other than `q[addr]` keeps its stored value, and a clock edge leaves those cells unchanged.
- R4: A rising clock edge in write mode stores `dIn` into cell `addr`. After a return to hold mode, `q[addr]` shows that value.
- R5: With `clrN`=0 and `enN`=0 (decode), `q[addr]` equals `dIn` and all other output bits are 0.
- R6: A clock edge in decode mode loads the stored contents with `dIn` in cell `addr` and 0 in every other cell. A following hold shows exactly that pattern.
- R7: With `clrN`=0 and `enN`=1 (clear), `q` is all zeros whatever the values of `addr` and `dIn`.
- R8: A clock edge in clear mode sets every stored cell to 0. A following hold shows `q` = 0.
- R9: The mode is decoded from {`clrN`,`enN`} as follows: 2'b11 hold, 2'b10 write, 2'b01 clear, 2'b00 decode. Output bit i corresponds to address value i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and clears land on its rising edge |
| dIn | input | 1 | Serial data bit |
| addr | input | 3 | Cell / output select |
| enN | input | 1 | Enable, active low |
| clrN | input | 1 | Common clear, active low |
| q | output | 8 | Parallel outputs, active high |

## Verification
A vector table steps through all four modes in mixed orders. Each output bit is compared against a bench-side model in every cycle. Writes of both polarities to scattered cells show whether only the addressed cell changes and whether the other cells keep their contents. A decode pass is followed by a hold, which shows whether decode leaves its one-hot pattern in storage instead of the old contents. A clear under every address and data combination, and a hold with an alternating pattern under every address and data combination, show whether any path lets `addr` or `dIn` leak into the outputs.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  typedef enum logic [1:0] {
    MODE_DECODE = 2'b00,
    MODE_CLEAR  = 2'b01,
    MODE_WRITE  = 2'b10,
    MODE_HOLD   = 2'b11
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic wrSel;     // load dIn into the addressed cell
    logic zeroSel;   // load 0 into the addressed cell
    logic zeroRest;  // load 0 into all non-addressed cells
    logic liveSel;   // addressed output shows dIn
    logic blankSel;  // addressed output forced low
    logic blankRest; // non-addressed outputs forced low
  } strobeT;

endpackage

// File: rtl/addr_latch_ctrl.sv
module addr_latch_ctrl
  import addr_latch_pkg::*;
(
  input  logic   clrN,
  input  logic   enN,
  output strobeT stb
);

  modeT mode;

  always_comb begin
    mode = modeT'({clrN, enN});
    stb  = '0;
    unique case (mode)
      MODE_HOLD: begin
        stb = '0;
      end
      MODE_WRITE: begin
        stb.wrSel   = 1'b1;
        stb.liveSel = 1'b1;
      end
      MODE_DECODE: begin
        stb.wrSel     = 1'b1;
        stb.zeroRest  = 1'b1;
        stb.liveSel   = 1'b1;
        stb.blankRest = 1'b1;
      end
      MODE_CLEAR: begin
        stb.zeroSel   = 1'b1;
        stb.zeroRest  = 1'b1;
        stb.blankSel  = 1'b1;
        stb.blankRest = 1'b1;
      end
      default: stb = '0;
    endcase
  end

endmodule

// File: rtl/addr_latch_dp.sv
module addr_latch_dp
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int CELLS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              dIn,
  input  logic [ADDR_W-1:0] addr,
  input  strobeT            stb,
  output logic [CELLS-1:0]  q
);

  logic [CELLS-1:0] cells;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic hit;
    logic nxt;

    assign hit = (addr == ADDR_W'(i));

    always_comb begin
      if (hit) begin
        if (stb.wrSel)        nxt = dIn;
        else if (stb.zeroSel) nxt = 1'b0;
        else                  nxt = cells[i];
      end else begin
        nxt = stb.zeroRest ? 1'b0 : cells[i];
      end
    end

    always_comb begin
      if (hit) begin
        if (stb.liveSel)       q[i] = dIn;
        else if (stb.blankSel) q[i] = 1'b0;
        else                   q[i] = cells[i];
      end else begin
        q[i] = stb.blankRest ? 1'b0 : cells[i];
      end
    end

    always_ff @(posedge clk) begin
      cells[i] <= nxt;
    end
  end

endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int CELLS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              dIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              enN,
  input  logic              clrN,
  output logic [CELLS-1:0]  q
);

  strobeT stb;

  addr_latch_ctrl u_ctrl (
    .clrN (clrN),
    .enN  (enN),
    .stb  (stb)
  );

  addr_latch_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk  (clk),
    .dIn  (dIn),
    .addr (addr),
    .stb  (stb),
    .q    (q)
  );

endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
  parameter int ADDR_W = 3,
  localparam int CELLS = 1 << ADDR_W
) (
  input logic              clk,
  input logic              dIn,
  input logic [ADDR_W-1:0] addr,
  input logic              enN,
  input logic              clrN,
  input logic [CELLS-1:0]  q
);

  // stored state is undefined until the first clear edge
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (!clrN && enN) armed <= 1'b1;
  end

  logic isHold, isWrite, isDecode, isClear;
  assign isHold   =  clrN &&  enN;
  assign isWrite  =  clrN && !enN;
  assign isDecode = !clrN && !enN;
  assign isClear  = !clrN &&  enN;

  logic [CELLS-1:0] selMask;
  logic [CELLS-1:0] oneHotD;
  assign selMask = CELLS'(1) << addr;
  assign oneHotD = CELLS'(dIn) << addr;

  // R7
  clear_outputs_low_chk: assert property (@(posedge clk) disable iff (!armed)
    isClear |-> (q == '0));

  // R5
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!armed)
    isDecode |-> (q == oneHotD));

  // R2
  write_live_chk: assert property (@(posedge clk) disable iff (!armed)
    isWrite |-> (((q & selMask) != '0) == dIn));

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(isHold) && isHold) |-> $stable(q));

  // R3
  write_others_kept_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(isWrite) && isWrite && $stable(addr)) |->
      ((q & ~selMask) == ($past(q) & ~selMask)));

  // R4
  write_stored_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(isWrite) && isHold) |-> (((q >> $past(addr)) & CELLS'(1)) == CELLS'($past(dIn))));

  // R8
  clear_stored_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(isClear) && isHold) |-> (q == '0));

  // R6
  decode_stored_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(isDecode) && isHold) |-> (q == (CELLS'($past(dIn)) << $past(addr))));

endmodule

bind addr_latch addr_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk  (clk),
  .dIn  (dIn),
  .addr (addr),
  .enN  (enN),
  .clrN (clrN),
  .q    (q)
);

// File: tb/sim_addr_latch.sv
module sim_addr_latch;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3;
  localparam int CELLS = 1 << ADDR_W;
  localparam int NVEC = 22;

  logic clk = 1'b0;
  logic dIn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic enN = 1'b1;
  logic clrN = 1'b1;
  logic [CELLS-1:0] q;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [CELLS-1:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_latch #(.ADDR_W(ADDR_W)) u0 (
    .clk (clk), .dIn (dIn), .addr (addr), .enN (enN), .clrN (clrN), .q (q)
  );

  // vector: {clrN, enN, addr[2:0], dIn}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b01_000_0, 6'b11_101_1, 6'b10_000_1, 6'b10_011_1,
    6'b10_111_1, 6'b11_010_1, 6'b10_011_0, 6'b10_101_1,
    6'b11_110_0, 6'b00_010_1, 6'b11_000_1, 6'b00_110_0,
    6'b11_110_1, 6'b10_001_1, 6'b10_110_1, 6'b01_100_1,
    6'b11_111_1, 6'b10_111_1, 6'b00_111_1, 6'b11_011_0,
    6'b10_010_0, 6'b11_000_0
  };

  function automatic logic [CELLS-1:0] expOut(logic c, logic e, logic [ADDR_W-1:0] a,
                                              logic d, logic [CELLS-1:0] st);
    logic [CELLS-1:0] r;
    case ({c, e})
      2'b11: r = st;
      2'b10: begin r = st; r[a] = d; end
      2'b00: r = CELLS'(d) << a;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tagFor(logic c, logic e);
    case ({c, e})
      2'b11: return "R1 R9";
      2'b10: return "R2 R3 R9";
      2'b00: return "R5 R9";
      default: return "R7 R9";
    endcase
  endfunction

  task automatic step(logic c, logic e, logic [ADDR_W-1:0] a, logic d, string tag);
    logic [CELLS-1:0] ex;
    @(negedge clk);
    clrN = c; enN = e; addr = a; dIn = d;
    #1;
    ex = expOut(c, e, a, d, model);
    checks++;
    if (q !== ex) begin
      fails++;
      $display("FAIL %s: q=%b expected %b (clrN=%b enN=%b addr=%0d dIn=%b)",
               tag, q, ex, c, e, a, d);
    end
    @(posedge clk);
    model = expOut(c, e, a, d, model);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // table walk, first entry is the reset-state check (R7, R8)
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3:1], VEC[i][0],
           tagFor(VEC[i][5], VEC[i][4]));
    end

    // R4: write alternating pattern, then read back in hold
    for (int i = 0; i < CELLS; i++) step(1'b1, 1'b0, ADDR_W'(i), i[0] ? 1'b0 : 1'b1, "R4 R2");
    step(1'b1, 1'b1, '0, 1'b0, "R4");

    // R1: hold ignores every address and data value
    for (int i = 0; i < 2 * CELLS; i++) step(1'b1, 1'b1, ADDR_W'(i >> 1), i[0], "R1");

    // R7: clear forces zero under every address and data value
    for (int i = 0; i < 2 * CELLS; i++) step(1'b0, 1'b1, ADDR_W'(i >> 1), i[0], "R7");
    // R8: stored contents cleared
    step(1'b1, 1'b1, 3'd5, 1'b1, "R8");

    // fill all ones, then decode sweep
    for (int i = 0; i < CELLS; i++) step(1'b1, 1'b0, ADDR_W'(i), 1'b1, "R2 R3");
    for (int i = 0; i < CELLS; i++) step(1'b0, 1'b0, ADDR_W'(i), 1'b1, "R5");
    // R6: decode leaves one-hot pattern of its last cycle
    step(1'b1, 1'b1, 3'd0, 1'b0, "R6");
    step(1'b0, 1'b0, 3'd3, 1'b0, "R5");
    step(1'b1, 1'b1, 3'd3, 1'b1, "R6");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule